// File: doc/BRIEF.md
# Eight-Channel Stepped Phase Dimmer

This block turns eight 8-bit brightness levels into eight on/off firing outputs for phase-angle dimming. Each mains half-cycle is covered by one dimming cycle. A dimming cycle is split into 255 equal time steps, and a step counter falls by one at every step. A channel turns on at the first step whose counter value is at or below the channel level. It then stays on until the next cycle begins, so a high level fires early in the half-cycle and a low level fires late. Zero-cross sensing and the drive stage for the power switch sit outside the block.

A system-clock divider produces a slow tick, and a fixed number of ticks makes up one step. At every step boundary the output port takes the word that was computed at the previous boundary. Only after that is the word for the next boundary built. Because of this, the port always lags the computation by one step. A parameter selects where the cycle restart comes from. In internal mode the block restarts itself after a fixed number of steps. In external mode a one-clock pulse on an input restarts it, for example a pulse from a zero-cross detector.

Top module: `phase_dimmer8`

## Requirements
- R1: After synchronous reset the port reads all zeros, the step counter is zero, and the first step boundary comes TICKS_PER_STEP ticks after reset is released.
- R2: A tick occurs every TICK_DIV clocks, and a step boundary occurs every TICKS_PER_STEP ticks after a restart. The port changes only at a step boundary.
- R3: At a step boundary the port is loaded with the word computed at the previous boundary. At the first boundary after a restart, the port therefore shows the final word of the cycle before.
- R4: At each boundary the counter decrements, wrapping from 0 to 255. A channel's bit is set in the newly computed word when its level is greater than or equal to the decremented counter. After boundary j following a restart, the counter holds (256 - j) mod 256.
- R5: Bits in the computed word are OR-accumulated across boundaries. They are cleared only at a boundary whose counter value was zero before the decrement, which is the first boundary after a restart and every 256th boundary after that.
- R6: The level of channel i is input bits [8i+7:8i], and channel i drives bit i of the port.
- R7: In internal mode a restart happens one tick after the 255th boundary since the last restart. A restart loads the counter with zero, restarts the tick and step timers, and leaves the port unchanged.
- R8: In external mode a restart pulse aborts the current cycle in the clock it arrives and applies the same initialisation. With no pulse, boundaries continue without limit and the counter wraps.
- R9: In internal mode the external restart input has no effect on the port.
- R10: Levels are sampled at each boundary. A level change made between boundaries affects only the word computed at the next boundary, and so reaches the port one boundary later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cycle_restart | input | 1 | One-clock restart pulse, used in external mode |
| levels_in | input | 64 | Eight 8-bit channel levels, channel i in bits [8i+7:8i] |
| dim_out | output | 8 | Firing outputs, bit i for channel i |

## Verification
The bench checks the port both one clock before and exactly at every boundary. Because of this, a design that put the port one step early, skipped the one-step lag, or miscounted the tick divider would show a mismatch against the arithmetic model. Level sweeps include the values 0, 1, 254 and 255:
- Level 0 must never fire in internal mode.
- Level 255 must fire at the very first computed step.

In external mode the bench runs beyond 256 boundaries. A design that failed to wrap the counter, or failed to clear the accumulated word at the zero count, would show the wrong all-on or stale word there. Mid-cycle aborts, an ignored restart pulse in internal mode, and levels that change at every step catch three more faults:
- a restart that disturbs the port;
- a restart input that leaks through in internal mode;
- a design that samples its levels at the wrong time or drops bits it had already latched.

// File: rtl/dimmer_pkg.sv
package dimmer_pkg;

    localparam int unsigned N_CH  = 8;
    localparam int unsigned LVL_W = 8;
    localparam int unsigned STEPS = (1 << LVL_W) - 1;

    typedef logic [LVL_W-1:0]         level_t;
    typedef logic [N_CH-1:0]          chan_word_t;
    typedef level_t [N_CH-1:0]        level_vec_t;

    typedef enum logic {
        RST_SRC_INTERNAL = 1'b0,
        RST_SRC_EXTERNAL = 1'b1
    } rst_src_e;

    typedef struct packed {
        level_t     count;
        chan_word_t pend;
    } step_state_t;

    function automatic chan_word_t hit_mask(level_vec_t lv, level_t thr);
        chan_word_t m;
        for (int i = 0; i < N_CH; i++) begin
            m[i] = (lv[i] >= thr);
        end
        return m;
    endfunction

endpackage

// File: rtl/dim_tick_gen.sv
module dim_tick_gen
    import dimmer_pkg::*;
#(
    parameter int unsigned TICK_DIV       = 125,
    parameter int unsigned TICKS_PER_STEP = 40,
    parameter rst_src_e    RESTART_SRC    = RST_SRC_INTERNAL
) (
    input  logic clk,
    input  logic rst,
    input  logic restart_in,
    output logic step_stb,
    output logic restart_eff
);

    localparam int unsigned DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int unsigned STP_W = (TICKS_PER_STEP > 1) ? $clog2(TICKS_PER_STEP) : 1;

    logic [DIV_W-1:0] div_q;
    logic [STP_W-1:0] tck_q;
    logic             tick;
    logic             step_end;

    assign tick     = (div_q == DIV_W'(TICK_DIV - 1));
    assign step_end = tick && (tck_q == STP_W'(TICKS_PER_STEP - 1));
    assign step_stb = step_end && !restart_eff;

    always_ff @(posedge clk) begin
        if (rst || restart_eff) begin
            div_q <= '0;
            tck_q <= '0;
        end else begin
            div_q <= tick ? '0 : div_q + 1'b1;
            if (tick) begin
                tck_q <= step_end ? '0 : tck_q + 1'b1;
            end
        end
    end

    generate
        if (RESTART_SRC == RST_SRC_INTERNAL) begin : g_int
            level_t bnd_q;
            logic   unused_ext;
            assign unused_ext  = restart_in;
            assign restart_eff = tick && (bnd_q == level_t'(STEPS));

            always_ff @(posedge clk) begin
                if (rst || restart_eff) begin
                    bnd_q <= '0;
                end else if (step_stb) begin
                    bnd_q <= bnd_q + 1'b1;
                end
            end
        end else begin : g_ext
            assign restart_eff = restart_in;
        end
    endgenerate

endmodule

// File: rtl/dim_step_core.sv
module dim_step_core
    import dimmer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic       step_stb,
    input  level_vec_t levels,
    output chan_word_t port_q,
    output level_t     count_q,
    output chan_word_t pend_q
);

    step_state_t st_q;
    step_state_t st_d;
    level_t      cnt_dec;

    always_comb begin
        cnt_dec     = st_q.count - 1'b1;
        st_d.count  = cnt_dec;
        st_d.pend   = ((st_q.count == '0) ? '0 : st_q.pend) | hit_mask(levels, cnt_dec);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            port_q <= '0;
        end else if (restart) begin
            st_q.count <= '0;
        end else if (step_stb) begin
            port_q <= st_q.pend;
            st_q   <= st_d;
        end
    end

    assign count_q = st_q.count;
    assign pend_q  = st_q.pend;

endmodule

// File: rtl/phase_dimmer8.sv
module phase_dimmer8
    import dimmer_pkg::*;
#(
    parameter int unsigned TICK_DIV       = 125,
    parameter int unsigned TICKS_PER_STEP = 40,
    parameter rst_src_e    RESTART_SRC    = RST_SRC_INTERNAL
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cycle_restart,
    input  logic [N_CH*LVL_W-1:0]   levels_in,
    output logic [N_CH-1:0]         dim_out
);

    logic       step_stb;
    logic       restart_eff;
    level_vec_t lv;
    level_t     step_count;
    chan_word_t pend_word;
    chan_word_t port_word;

    assign lv      = levels_in;
    assign dim_out = port_word;

    dim_tick_gen #(
        .TICK_DIV       (TICK_DIV),
        .TICKS_PER_STEP (TICKS_PER_STEP),
        .RESTART_SRC    (RESTART_SRC)
    ) u_tick (
        .clk         (clk),
        .rst         (rst),
        .restart_in  (cycle_restart),
        .step_stb    (step_stb),
        .restart_eff (restart_eff)
    );

    dim_step_core u_core (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart_eff),
        .step_stb (step_stb),
        .levels   (lv),
        .port_q   (port_word),
        .count_q  (step_count),
        .pend_q   (pend_word)
    );

endmodule

// File: rtl/dim_checker.sv
module dim_checker
    import dimmer_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       step_stb,
    input logic       restart,
    input level_t     cnt,
    input chan_word_t pend,
    input chan_word_t port
);

    // R2: without a boundary the port holds
    p_port_only_on_step_r2: assert property (@(posedge clk) disable iff (rst)
        !step_stb |=> $stable(port));

    // R3: port takes the word computed one step earlier
    p_port_lags_r3: assert property (@(posedge clk) disable iff (rst)
        (step_stb && !restart) |=> (port == $past(pend)));

    // R4: counter decrements with wrap at each boundary
    p_count_dec_r4: assert property (@(posedge clk) disable iff (rst)
        (step_stb && !restart) |=> (cnt == level_t'($past(cnt) - 1'b1)));

    // R5: accumulated bits never drop except at the zero count
    p_latch_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (step_stb && !restart && cnt != '0) |=> ((pend & $past(pend)) == $past(pend)));

    // R7: restart leaves the port untouched
    p_restart_keeps_port_r7: assert property (@(posedge clk) disable iff (rst)
        restart |=> $stable(port));

    // R8: restart loads the counter with zero
    p_restart_zero_r8: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt == '0));

endmodule

bind phase_dimmer8 dim_checker u_dim_chk (
    .clk      (clk),
    .rst      (rst),
    .step_stb (step_stb),
    .restart  (restart_eff),
    .cnt      (step_count),
    .pend     (pend_word),
    .port     (port_word)
);

// File: tb/test_phase_dimmer8.sv
module test_phase_dimmer8;
    import dimmer_pkg::*;

    localparam int DIV = 2;
    localparam int TPS = 3;
    localparam int S   = DIV * TPS;

    logic        clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_a = 1'b1, rst_b = 1'b1;
    logic        rs_a = 1'b0, rs_b = 1'b0;
    logic [63:0] lv_a, lv_b;
    logic [7:0]  out_a, out_b;

    phase_dimmer8 #(.TICK_DIV(DIV), .TICKS_PER_STEP(TPS), .RESTART_SRC(RST_SRC_INTERNAL))
    i_phase_dimmer8 (.clk(clk), .rst(rst_a), .cycle_restart(rs_a), .levels_in(lv_a), .dim_out(out_a));

    phase_dimmer8 #(.TICK_DIV(DIV), .TICKS_PER_STEP(TPS), .RESTART_SRC(RST_SRC_EXTERNAL))
    i_phase_dimmer8_ext (.clk(clk), .rst(rst_b), .cycle_restart(rs_b), .levels_in(lv_b), .dim_out(out_b));

    int          n_chk = 0;
    int          n_bad = 0;
    int          m_j;
    logic [7:0]  m_acc, m_port;
    logic [15:0] lfsr = 16'hACE1;
    bit          done = 1'b0;

    function automatic logic [7:0] hits(logic [63:0] lv, int thr);
        logic [7:0] m;
        for (int i = 0; i < 8; i++) begin
            m[i] = (int'(lv[i*8 +: 8]) >= thr);
        end
        return m;
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_j = 0; m_acc = '0; m_port = '0;
    endtask

    task automatic model_bnd(logic [63:0] lv);
        int cb, ca;
        m_j++;
        cb = ((257 - m_j) % 256 + 256) % 256;
        ca = (cb + 255) % 256;
        m_port = m_acc;
        if (cb == 0) m_acc = '0;
        m_acc = m_acc | hits(lv, ca);
    endtask

    task automatic step(bit ext, string tag, bit churn);
        repeat (S - 1) @(posedge clk);
        @(negedge clk);
        check({tag, " R2 hold"}, ext ? out_b : out_a, m_port);
        @(posedge clk);
        @(negedge clk);
        model_bnd(ext ? lv_b : lv_a);
        check(tag, ext ? out_b : out_a, m_port);
        if (churn) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            lv_a = {lv_a[47:0], lfsr};
        end
    endtask

    task automatic int_restart_gap();
        repeat (DIV) @(posedge clk);
        @(negedge clk);
        check("R7 restart keeps port", out_a, m_port);
        m_j = 0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        // ch7..ch0 = 3C C3 FF FE 80 7F 01 00
        lv_a = 64'h3CC3_FFFE_807F_0100;
        lv_b = 64'h00FF_0280_FD01_40FE;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_a = 1'b0;
        model_reset();
        check("R1 reset port", out_a, 8'h00);

        for (int k = 0; k < 255; k++) step(1'b0, "R4/R6", 1'b0);
        int_restart_gap();

        for (int k = 0; k < 255; k++) begin
            if (k == 100) rs_a = 1'b1;
            if (k == 110) rs_a = 1'b0;
            step(1'b0, (k >= 100 && k <= 110) ? "R9 ignored restart" : "R3/R5", 1'b0);
        end
        int_restart_gap();

        for (int k = 0; k < 255; k++) step(1'b0, "R10 level sampling", 1'b1);

        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_b = 1'b0;
        model_reset();
        check("R1 reset port ext", out_b, 8'h00);

        for (int k = 0; k < 260; k++) step(1'b1, "R8 wrap", 1'b0);

        repeat (2) @(posedge clk);
        @(negedge clk);
        rs_b = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rs_b = 1'b0;
        check("R8 abort keeps port", out_b, m_port);
        m_j = 0;
        for (int k = 0; k < 20; k++) step(1'b1, "R8 abort", 1'b0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R2 watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

endmodule